// File: doc/BRIEF.md
# Transmit Segmentation Channel State Engine

This block holds the complete transmit state of one segmentation channel and walks it forward on every cell opportunity. The state is made up of three parts. The first is a negated packet-length counter and a negated buffer-length counter. The second is a byte-granular pointer into the current buffer. The third is a stored header word and a descriptor-ring position. An enable bit and the ring position are set through a small configuration write port.

When an opportunity arrives and the channel is enabled, the engine gathers 48 payload bytes. It issues transfer requests of address and byte count, one at a time, each accepted by a single-cycle acknowledge. Whenever the current buffer runs dry it fetches the next ring descriptor. At the end it presents one cell record: the 32-bit cell header, a last-cell flag and a padding count.

A disabled or faulted channel produces an idle cell record instead. A descriptor that is inconsistent with the packet length raises a sticky error and switches the channel off.

Top module: `segtx_chan`

## Requirements
- R1: When the channel enable is clear or the error flag is set, a cell opportunity yields one record with `cell_idle`=1 and raises no descriptor fetch and no transfer request.
- R2: The descriptor control word carries the end-of-chain flag in bit 29, the payload-type flag in bit 27, a negated packet cell count in bits 26:16 and a negated buffer byte count in bits 15:0. The packet count is taken only from the first descriptor of a packet and rises by one per non-idle cell. When it reaches zero on the cell that drains the end-of-chain buffer, the packet completes without error.
- R3: Each transfer request asks for min(bytes still missing from the 48-byte cell, bytes left in the buffer). A single cell may therefore draw from several buffers of one packet.
- R4: The first transfer from a buffer uses the descriptor's buffer pointer (word `desc_buf_ptr`) as its address. Each later transfer from that buffer starts where the previous one ended.
- R5: Every header word is taken only from the first descriptor of a packet. A non-last cell carries {4'b0000, hdr[27:0]}. The last cell carries {4'b0000, hdr[27:4], hdr[31:29], hdr[28]}.
- R6: When the end-of-chain buffer empties before the cell is full, the cell is marked last and `cell_pad` reports the unfilled byte count. Non-last cells report zero padding, and a last cell that fills the cell exactly reports zero.
- R7: A descriptor is read from {ring_base[31:12], index[11:4], 4'b0000}. A configuration write loads both parts from `cfg_ring_addr`. Each fetch advances the index by one, with 255 wrapping to 0, while the base is kept.
- R8: If the end-of-chain buffer empties while the packet count is not reaching zero, or the count reaches zero on a cell that is not last, `err` rises and stays set. Every later opportunity then yields an idle cell.
- R9: A fetched descriptor with bit 27 set raises `err`, issues no transfer, and turns that opportunity into an idle cell.
- R10: After reset no request or cell record is active and `err` is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load enable and ring address (accepted while waiting for an opportunity) |
| cfg_enable | input | 1 | Channel enable value |
| cfg_ring_addr | input | 32 | Ring base and starting entry index |
| cell_opp | input | 1 | Cell opportunity pulse |
| desc_req | output | 1 | Descriptor fetch request |
| desc_addr | output | 32 | Descriptor address |
| desc_valid | input | 1 | Descriptor words valid, completes the fetch |
| desc_ctrl | input | 32 | Descriptor control word |
| desc_buf_ptr | input | 32 | Descriptor buffer start address |
| desc_hdr | input | 32 | Descriptor header word |
| xfer_req | output | 1 | Payload transfer request |
| xfer_addr | output | 32 | Transfer source byte address |
| xfer_len | output | 6 | Transfer byte count |
| xfer_ack | input | 1 | Transfer accepted |
| cell_valid | output | 1 | Cell record valid (one cycle) |
| cell_idle | output | 1 | Record is an idle cell |
| cell_last | output | 1 | Record is the last cell of its packet |
| cell_hdr | output | 32 | Cell header word |
| cell_pad | output | 6 | Padding byte count |
| err | output | 1 | Sticky length or type fault |

## Verification
The hardest state to reach is a cell whose payload straddles a buffer boundary inside one packet. It requires that the following descriptor's header and packet count are ignored while its pointer and byte count are used. The bench gets there with a packet of a 20-byte buffer followed by an end-of-chain 40-byte buffer. The second descriptor carries a different header and a wrong packet count. A clean finish then shows that the header and count came from the first descriptor alone. Ring wrap is reached by configuring the index to 255 directly, rather than by stepping through the whole ring.

// File: rtl/segtx_pkg.sv
package segtx_pkg;
   typedef enum logic [1:0] {
      ST_WAIT  = 2'd0,
      ST_MOVE  = 2'd1,
      ST_FETCH = 2'd2,
      ST_OUT   = 2'd3
   } segtx_state_e;

   localparam int CTL_CHAIN_END = 29;
   localparam int CTL_TYPE_BIT  = 27;
   localparam int CTL_PKT_LSB   = 16;
   localparam int HDR_W         = 32;
endpackage

// File: rtl/segtx_xfer_size.sv
module segtx_xfer_size #(
   parameter int BUF_W  = 16,
   parameter int NEED_W = 6
) (
   input  logic [NEED_W-1:0] need,
   input  logic [BUF_W-1:0]  buf_neg,
   output logic [NEED_W-1:0] len
);
   logic [BUF_W-1:0] remain;

   generate
      if (BUF_W < NEED_W) begin : g_bad
         $error("segtx_xfer_size: BUF_W narrower than NEED_W");
      end
   endgenerate

   always_comb begin
      remain = '0 - buf_neg;
      if (remain < BUF_W'(need)) len = NEED_W'(remain);
      else                       len = need;
   end
endmodule

// File: rtl/segtx_ring.sv
module segtx_ring #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              step,
   output logic [ADDR_W-1:0] addr
);
   localparam int LO     = IDX_W + 4;
   localparam int BASE_W = ADDR_W - LO;

   logic [BASE_W-1:0] base_q;
   logic [IDX_W-1:0]  idx_q;

   generate
      if (BASE_W < 1) begin : g_bad
         $error("segtx_ring: ADDR_W too small for IDX_W");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         idx_q  <= '0;
      end else if (load) begin
         base_q <= load_addr[ADDR_W-1:LO];
         idx_q  <= load_addr[LO-1:4];
      end else if (step) begin
         idx_q  <= idx_q + IDX_W'(1);
      end
   end

   assign addr = {base_q, idx_q, 4'b0000};
endmodule

// File: rtl/segtx_hdr_fmt.sv
module segtx_hdr_fmt (
   input  logic [31:0] hdr,
   input  logic        last,
   output logic [31:0] cell_hdr
);
   always_comb begin
      if (last) cell_hdr = {4'b0000, hdr[27:4], hdr[31:29], hdr[28]};
      else      cell_hdr = {4'b0000, hdr[27:0]};
   end
endmodule

// File: rtl/segtx_chan.sv
module segtx_chan
   import segtx_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int CELL_BYTES = 48,
   parameter int PKT_W      = 11,
   parameter int BUF_W      = 16,
   parameter int IDX_W      = 8,
   localparam int NEED_W    = $clog2(CELL_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cfg_enable,
   input  logic [ADDR_W-1:0] cfg_ring_addr,
   input  logic              cell_opp,
   output logic              desc_req,
   output logic [ADDR_W-1:0] desc_addr,
   input  logic              desc_valid,
   input  logic [31:0]       desc_ctrl,
   input  logic [ADDR_W-1:0] desc_buf_ptr,
   input  logic [31:0]       desc_hdr,
   output logic              xfer_req,
   output logic [ADDR_W-1:0] xfer_addr,
   output logic [NEED_W-1:0] xfer_len,
   input  logic              xfer_ack,
   output logic              cell_valid,
   output logic              cell_idle,
   output logic              cell_last,
   output logic [31:0]       cell_hdr,
   output logic [NEED_W-1:0] cell_pad,
   output logic              err
);
   generate
      if (BUF_W > CTL_PKT_LSB) begin : g_bad_buf
         $error("segtx_chan: BUF_W overlaps packet field");
      end
      if (CTL_PKT_LSB + PKT_W > CTL_TYPE_BIT) begin : g_bad_pkt
         $error("segtx_chan: PKT_W overlaps type bit");
      end
   endgenerate

   segtx_state_e      state_q;
   logic              en_q, err_q, open_q, eoc_q, idle_q, last_q;
   logic [NEED_W-1:0] need_q;
   logic [BUF_W-1:0]  buf_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [PKT_W-1:0]  pkt_q, pkt_next;
   logic [31:0]       hdr_q;
   logic [NEED_W-1:0] len_w;
   logic              ring_load, ring_step;
   logic              unused_bits;

   assign unused_bits = ^{desc_ctrl[31:30], desc_ctrl[28],
                          desc_ctrl[CTL_TYPE_BIT-1:CTL_PKT_LSB+PKT_W],
                          desc_ctrl[CTL_PKT_LSB-1:BUF_W]};

   segtx_xfer_size #(.BUF_W(BUF_W), .NEED_W(NEED_W)) u_size (
      .need(need_q), .buf_neg(buf_q), .len(len_w));

   assign ring_load = (state_q == ST_WAIT) && cfg_wr;
   assign ring_step = (state_q == ST_FETCH) && desc_valid;

   segtx_ring #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ring (
      .clk(clk), .rst_n(rst_n), .load(ring_load), .load_addr(cfg_ring_addr),
      .step(ring_step), .addr(desc_addr));

   segtx_hdr_fmt u_hdr (.hdr(hdr_q), .last(last_q), .cell_hdr(cell_hdr));

   assign pkt_next   = pkt_q + PKT_W'(1);
   assign desc_req   = (state_q == ST_FETCH);
   assign xfer_req   = (state_q == ST_MOVE) && open_q && (buf_q != '0) && (need_q != '0);
   assign xfer_addr  = ptr_q;
   assign xfer_len   = len_w;
   assign cell_valid = (state_q == ST_OUT);
   assign cell_idle  = idle_q;
   assign cell_last  = last_q;
   assign cell_pad   = last_q ? need_q : '0;
   assign err        = err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_WAIT;
         en_q    <= 1'b0;
         err_q   <= 1'b0;
         open_q  <= 1'b0;
         eoc_q   <= 1'b0;
         idle_q  <= 1'b0;
         last_q  <= 1'b0;
         need_q  <= '0;
         buf_q   <= '0;
         ptr_q   <= '0;
         pkt_q   <= '0;
         hdr_q   <= '0;
      end else begin
         unique case (state_q)
            ST_WAIT: begin
               if (cfg_wr) en_q <= cfg_enable;
               if (cell_opp) begin
                  need_q <= NEED_W'(CELL_BYTES);
                  last_q <= 1'b0;
                  idle_q <= !en_q || err_q;
                  state_q <= (!en_q || err_q) ? ST_OUT : ST_MOVE;
               end
            end
            ST_MOVE: begin
               if (buf_q == '0) begin
                  if (open_q && eoc_q) begin
                     last_q  <= 1'b1;
                     state_q <= ST_OUT;
                  end else begin
                     state_q <= ST_FETCH;
                  end
               end else if (need_q == '0) begin
                  state_q <= ST_OUT;
               end else if (xfer_ack) begin
                  ptr_q  <= ptr_q + ADDR_W'(len_w);
                  buf_q  <= buf_q + BUF_W'(len_w);
                  need_q <= need_q - len_w;
               end
            end
            ST_FETCH: begin
               if (desc_valid) begin
                  if (desc_ctrl[CTL_TYPE_BIT]) begin
                     err_q   <= 1'b1;
                     en_q    <= 1'b0;
                     idle_q  <= 1'b1;
                     state_q <= ST_OUT;
                  end else begin
                     buf_q <= desc_ctrl[BUF_W-1:0];
                     ptr_q <= desc_buf_ptr;
                     eoc_q <= desc_ctrl[CTL_CHAIN_END];
                     if (!open_q) begin
                        hdr_q  <= desc_hdr;
                        pkt_q  <= desc_ctrl[CTL_PKT_LSB +: PKT_W];
                        open_q <= 1'b1;
                     end
                     state_q <= ST_MOVE;
                  end
               end
            end
            ST_OUT: begin
               if (!idle_q) begin
                  pkt_q <= pkt_next;
                  if (last_q) open_q <= 1'b0;
                  if (last_q != (pkt_next == '0)) begin
                     err_q <= 1'b1;
                     en_q  <= 1'b0;
                  end
               end
               last_q  <= 1'b0;
               idle_q  <= 1'b0;
               state_q <= ST_WAIT;
            end
            default: state_q <= ST_WAIT;
         endcase
      end
   end

   // R1: an off channel answers an opportunity with an idle record next cycle
   a_r1_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && cell_opp && !en_q) |=> (cell_valid && cell_idle));

   // R3: a transfer is never empty and never larger than one cell
   a_r3_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |-> (xfer_len != '0 && xfer_len <= NEED_W'(CELL_BYTES)));

   // R7: every completed fetch steps the entry index by one, base kept
   a_r7_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_req && desc_valid) |=>
         (desc_addr[IDX_W+3:4] == $past(desc_addr[IDX_W+3:4]) + IDX_W'(1)) &&
         $stable(desc_addr[ADDR_W-1:IDX_W+4]));

   // R8: the fault flag never clears without reset
   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   // R8: a faulted channel moves no payload
   a_r8_no_xfer_after_err: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !xfer_req);
endmodule

// File: tb/segtx_chan_tb_top.sv
module segtx_chan_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0, cfg_enable = 1'b0;
   logic [31:0] cfg_ring_addr = '0;
   logic        cell_opp = 1'b0;
   logic        desc_req, desc_valid = 1'b0;
   logic [31:0] desc_addr, desc_ctrl = '0, desc_buf_ptr = '0, desc_hdr = '0;
   logic        xfer_req, xfer_ack = 1'b0;
   logic [31:0] xfer_addr;
   logic [5:0]  xfer_len, cell_pad;
   logic        cell_valid, cell_idle, cell_last, err;
   logic [31:0] cell_hdr;

   always #2.5 clk = ~clk;

   segtx_chan dut_i (.*);

   logic [31:0] t_ctrl [256];
   logic [31:0] t_ptr  [256];
   logic [31:0] t_hdr  [256];
   logic [31:0] xa [64];
   int          xl [64];
   logic [31:0] da [16];
   logic [31:0] ch [16];
   logic        ci [16];
   logic        cl [16];
   int          cp [16];
   int xn = 0, dn = 0, cn = 0;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always @(negedge clk) begin
      xfer_ack   <= xfer_req;
      desc_valid <= desc_req;
      if (xfer_req && xn < 64) begin xa[xn] = xfer_addr; xl[xn] = int'(xfer_len); xn++; end
      if (desc_req) begin
         desc_ctrl    <= t_ctrl[desc_addr[11:4]];
         desc_buf_ptr <= t_ptr[desc_addr[11:4]];
         desc_hdr     <= t_hdr[desc_addr[11:4]];
         if (dn < 16) begin da[dn] = desc_addr; dn++; end
      end
      if (cell_valid && cn < 16) begin
         ch[cn] = cell_hdr; ci[cn] = cell_idle; cl[cn] = cell_last; cp[cn] = int'(cell_pad); cn++;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_ctrl(input bit eoc, input bit typ, input int cells, input int bytes);
      logic [10:0] p;
      logic [15:0] b;
      p = 11'(-cells);
      b = 16'(-bytes);
      return {2'b00, eoc, 1'b0, typ, p, b};
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      xn = 0; dn = 0; cn = 0;
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic do_cfg(input bit en, input logic [31:0] ring);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_enable = en; cfg_ring_addr = ring;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic do_opp();
      int c0;
      c0 = cn;
      @(negedge clk);
      cell_opp = 1'b1;
      @(negedge clk);
      cell_opp = 1'b0;
      for (int k = 0; k < 300 && cn == c0; k++) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset_state();
      do_reset();
      check("R10 desc_req", desc_req, 0);
      check("R10 xfer_req", xfer_req, 0);
      check("R10 cell_valid", cell_valid, 0);
      check("R10 err", err, 0);
   endtask

   task automatic t_disabled();
      do_reset();
      do_cfg(0, 32'h0001_0000);
      do_opp();
      check("R1 cell count", cn, 1);
      check("R1 idle", ci[0], 1);
      check("R1 no fetch", dn, 0);
      check("R1 no xfer", xn, 0);
   endtask

   task automatic t_single_buffer();
      do_reset();
      t_ctrl[3] = mk_ctrl(1, 0, 3, 100); t_ptr[3] = 32'h1000_0003; t_hdr[3] = 32'h7123_4560;
      do_cfg(1, 32'h1234_5030);
      do_opp(); do_opp(); do_opp();
      check("R7 first desc addr", da[0], 32'h1234_5030);
      check("R7 one fetch", dn, 1);
      check("R4 addr0", xa[0], 32'h1000_0003); check("R3 len0", xl[0], 48);
      check("R4 addr1", xa[1], 32'h1000_0033); check("R3 len1", xl[1], 48);
      check("R4 addr2", xa[2], 32'h1000_0063); check("R3 len2", xl[2], 4);
      check("R5 hdr normal", ch[0], 32'h0123_4560);
      check("R6 pad nonlast", cp[1], 0);
      check("R2 not last", cl[1], 0);
      check("R2 last", cl[2], 1);
      check("R5 hdr last", ch[2], 32'h0123_4567);
      check("R6 pad", cp[2], 44);
      check("R2 no err", err, 0);
   endtask

   task automatic t_span();
      do_reset();
      t_ctrl[0] = mk_ctrl(0, 0, 2, 20); t_ptr[0] = 32'h2000; t_hdr[0] = 32'h7123_4560;
      t_ctrl[1] = mk_ctrl(1, 0, 7, 40); t_ptr[1] = 32'h3000; t_hdr[1] = 32'hFFFF_FFFF;
      do_cfg(1, 32'h0001_0000);
      do_opp(); do_opp();
      check("R3 span xfers", xn, 3);
      check("R4 span a0", xa[0], 32'h2000); check("R3 span l0", xl[0], 20);
      check("R4 span a1", xa[1], 32'h3000); check("R3 span l1", xl[1], 28);
      check("R4 span a2", xa[2], 32'h301C); check("R3 span l2", xl[2], 12);
      check("R7 second desc", da[1], 32'h0001_0010);
      check("R5 hdr from first", ch[0], 32'h0123_4560);
      check("R5 last hdr from first", ch[1], 32'h0123_4567);
      check("R6 span pad", cp[1], 36);
      check("R2 count from first desc", err, 0);
   endtask

   task automatic t_wrap_exact();
      do_reset();
      t_ctrl[255] = mk_ctrl(1, 0, 1, 48); t_ptr[255] = 32'h4000; t_hdr[255] = 32'h0000_0010;
      t_ctrl[0]   = mk_ctrl(1, 0, 1, 48); t_ptr[0]   = 32'h5000; t_hdr[0]   = 32'h0000_0020;
      do_cfg(1, 32'hABCD_EFF0);
      do_opp(); do_opp();
      check("R7 idx 255", da[0], 32'hABCD_EFF0);
      check("R7 wrap to 0", da[1], 32'hABCD_E000);
      check("R6 exact last", cl[0], 1);
      check("R6 exact pad", cp[0], 0);
      check("R5 second pkt hdr", ch[1], 32'h0000_0020);
      check("R2 exact no err", err, 0);
   endtask

   task automatic t_short_chain();
      do_reset();
      t_ctrl[0] = mk_ctrl(1, 0, 2, 10); t_ptr[0] = 32'h6000; t_hdr[0] = 32'h0;
      do_cfg(1, 32'h0002_0000);
      do_opp();
      check("R8 last on short", cl[0], 1);
      check("R8 err short", err, 1);
      do_opp();
      check("R8 idle after err", ci[1], 1);
      check("R8 no fetch after err", dn, 1);
   endtask

   task automatic t_long_chain();
      do_reset();
      t_ctrl[0] = mk_ctrl(1, 0, 1, 100); t_ptr[0] = 32'h7000; t_hdr[0] = 32'h0;
      do_cfg(1, 32'h0003_0000);
      do_opp();
      check("R8 nonlast at zero", cl[0], 0);
      check("R8 err long", err, 1);
   endtask

   task automatic t_bad_type();
      do_reset();
      t_ctrl[0] = mk_ctrl(1, 1, 1, 48); t_ptr[0] = 32'h8000; t_hdr[0] = 32'h0;
      do_cfg(1, 32'h0004_0000);
      do_opp();
      check("R9 err", err, 1);
      check("R9 idle", ci[0], 1);
      check("R9 no xfer", xn, 0);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin t_ctrl[i] = '0; t_ptr[i] = '0; t_hdr[i] = '0; end
      t_reset_state();
      t_disabled();
      t_single_buffer();
      t_span();
      t_wrap_exact();
      t_short_chain();
      t_long_chain();
      t_bad_type();
      done = 1;
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end
endmodule